// File: doc/BRIEF.md
# Masked Port-Change Latched Interrupt

This block watches seven port levels and raises an interrupt when any port that software has chosen to watch moves away from a stored reference pattern. Software loads a 7-bit watch mask, then issues a configuration write with the enable bit set. That write copies the current levels into a reference snapshot and arms detection. From then on, a difference on any watched bit, however brief, latches the active-high interrupt.

Detection is one-shot. A detected change latches the interrupt and disarms the compare. Any access to the mask register, read or write, drops the interrupt and leaves detection off. Software must issue another enabling configuration write before the block watches again, and that write also takes a new snapshot. The port levels come in asynchronously and pass through a synchronizer chain first. The snapshot is taken from the synchronized levels.

Top module: `port_change_irq`

## Requirements
- R1: After reset, `irq` is 0, `mask_rdata` is 0 and detection is disarmed. With mask 0x7F, moving the ports produces no interrupt until an enabling configuration write is made.
- R2: A cycle with `mask_wr` high stores `mask_wdata`. From the next cycle on, `mask_rdata` shows the stored value. Bit i of the mask belongs to `port_in[i]`.
- R3: A cycle with `cfg_wr` and `cfg_en` both high copies the synchronized port levels into the snapshot, arms detection and forces `irq` to 0 on the next cycle.
- R4: While detection is armed, a change on a port whose mask bit is 1 sets `irq` at the third rising clock edge after the change appears on `port_in`. Two edges are for synchronization and one is for the latch.
- R5: A change on a port whose mask bit is 0 never sets `irq`.
- R6: A watched port that differs from its snapshot for only one clock cycle still sets `irq`.
- R7: Once set, `irq` stays at 1 through further port changes, and also after the ports return to the snapshot pattern, until it is cleared.
- R8: A cycle with `mask_rd` or `mask_wr` high clears `irq` on the next cycle. A read leaves the stored mask unchanged.
- R9: After `irq` has been cleared, later port changes do not set it again until a new configuration write with `cfg_en` high is made.
- R10: A configuration write with `cfg_en` low disarms detection. It does not clear an `irq` that is already set.
- R11: If a mask access falls in the same cycle in which a detection would latch, `irq` stays 0 and detection ends.
- R12: An enabling configuration write made while detection is armed replaces the snapshot. Levels that match the new snapshot do not set `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_in | input | 7 | Asynchronous port levels being watched |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable bit carried by the configuration write |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 7 | Mask write data; 1 watches a port |
| mask_rd | input | 1 | Mask register read strobe |
| irq | output | 1 | Sticky active-high change interrupt |
| mask_rdata | output | 7 | Current mask contents |

## Verification
The bench checks the single-cycle pulse. A design that compares against a registered edge, or samples too slowly, would miss it and leave `irq` low. It also returns the ports to the snapshot pattern after a hit. A level-following design would drop `irq` at that point, and the bench expects it to stay high. A mask read is used to clear the interrupt, and the ports are then moved again. A design that clears `irq` but forgets to disarm would raise it a second time. Finally, a mask access is timed to the exact cycle in which a hit would latch, and a snapshot is retaken while the block is armed. A wrong priority would set `irq` in the first case, and a stale snapshot would report a change that is no longer there in the second.

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int NPORT       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] port_in,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic             mask_wr,
  input  logic [NPORT-1:0] mask_wdata,
  input  logic             mask_rd,
  output logic             irq,
  output logic [NPORT-1:0] mask_rdata
);

  logic [NPORT-1:0] sync_q [SYNC_STAGES];
  logic [NPORT-1:0] port_s;
  logic [NPORT-1:0] snap_q;
  logic [NPORT-1:0] mask_q;
  logic             armed;
  logic             irq_q;
  logic             arm_req;
  logic             disarm_req;
  logic             mask_acc;
  logic             hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= port_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign port_s     = sync_q[SYNC_STAGES-1];
  assign arm_req    = cfg_wr & cfg_en;
  assign disarm_req = cfg_wr & ~cfg_en;
  assign mask_acc   = mask_wr | mask_rd;
  assign hit        = armed & |((port_s ^ snap_q) & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      mask_q <= '0;
    end else begin
      if (arm_req) snap_q <= port_s;
      if (mask_wr) mask_q <= mask_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (arm_req)                          armed <= 1'b1;
      else if (mask_acc | disarm_req | hit) armed <= 1'b0;

      if (arm_req | mask_acc) irq_q <= 1'b0;
      else if (hit)           irq_q <= 1'b1;
    end
  end

  assign irq        = irq_q;
  assign mask_rdata = mask_q;

endmodule

module port_change_irq_chk #(
  parameter int NPORT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             cfg_en,
  input logic             mask_wr,
  input logic             mask_rd,
  input logic [NPORT-1:0] mask_wdata,
  input logic [NPORT-1:0] mask_rdata,
  input logic             irq,
  input logic             armed
);

  // R2
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask_rdata == $past(mask_wdata));

  // R8
  read_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd && !mask_wr) |=> $stable(mask_rdata));

  // R3
  arm_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_en) |=> !irq);

  // R8
  access_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr || mask_rd) |=> !irq);

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !mask_wr && !mask_rd && !(cfg_wr && cfg_en)) |=> irq);

  // R9
  rise_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !armed) |=> !irq);

  // R9
  stay_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !(cfg_wr && cfg_en)) |=> !armed);

  // R10
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_en) |=> !armed);

endmodule

bind port_change_irq port_change_irq_chk #(.NPORT(NPORT)) u_chk (.*);

// File: tb/port_change_irq_bench.sv
module port_change_irq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] port_in = '0;
  logic       cfg_wr = 1'b0;
  logic       cfg_en = 1'b0;
  logic       mask_wr = 1'b0;
  logic [6:0] mask_wdata = '0;
  logic       mask_rd = 1'b0;
  logic       irq;
  logic [6:0] mask_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  port_change_irq u_port_change_irq (
    .clk(clk), .rst_n(rst_n), .port_in(port_in),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_rd(mask_rd),
    .irq(irq), .mask_rdata(mask_rdata)
  );

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ports(input logic [6:0] v);
    port_in = v;
    cyc(4);
  endtask

  task automatic cfg(input logic en);
    cfg_wr = 1'b1; cfg_en = en;
    cyc(1);
    cfg_wr = 1'b0; cfg_en = 1'b0;
  endtask

  task automatic wr_mask(input logic [6:0] m);
    mask_wr = 1'b1; mask_wdata = m;
    cyc(1);
    mask_wr = 1'b0;
  endtask

  task automatic rd_mask();
    mask_rd = 1'b1;
    cyc(1);
    mask_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq after reset", {6'b0, irq}, 7'h0);
    check("R1 mask after reset", mask_rdata, 7'h00);
    wr_mask(7'h7F);
    set_ports(7'h55);
    check("R1 no detect before arming", {6'b0, irq}, 7'h0);
  endtask

  task automatic t_mask_rw();
    wr_mask(7'h2A);
    check("R2 mask readback", mask_rdata, 7'h2A);
    rd_mask();
    check("R8 read keeps mask", mask_rdata, 7'h2A);
  endtask

  task automatic t_basic_hit();
    wr_mask(7'h01);
    set_ports(7'h00);
    cfg(1'b1);
    check("R3 irq low after arm", {6'b0, irq}, 7'h0);
    port_in = 7'h01;
    cyc(2);
    check("R4 not yet after two edges", {6'b0, irq}, 7'h0);
    cyc(1);
    check("R4 set on third edge", {6'b0, irq}, 7'h1);
    set_ports(7'h00);
    check("R7 holds after return", {6'b0, irq}, 7'h1);
    set_ports(7'h7F);
    check("R7 holds on more changes", {6'b0, irq}, 7'h1);
    rd_mask();
    check("R8 read clears irq", {6'b0, irq}, 7'h0);
    set_ports(7'h00);
    set_ports(7'h01);
    check("R9 no detect after clear", {6'b0, irq}, 7'h0);
  endtask

  task automatic t_masked();
    wr_mask(7'h0F);
    set_ports(7'h00);
    cfg(1'b1);
    set_ports(7'h70);
    check("R5 masked ports ignored", {6'b0, irq}, 7'h0);
    set_ports(7'h78);
    check("R4 unmasked bit 3 detected", {6'b0, irq}, 7'h1);
    wr_mask(7'h0F);
    check("R8 write clears irq", {6'b0, irq}, 7'h0);
    set_ports(7'h00);
    check("R9 still disarmed", {6'b0, irq}, 7'h0);
  endtask

  task automatic t_pulse();
    wr_mask(7'h40);
    set_ports(7'h00);
    cfg(1'b1);
    port_in = 7'h40;
    cyc(1);
    port_in = 7'h00;
    cyc(4);
    check("R6 one-cycle pulse latched", {6'b0, irq}, 7'h1);
    rd_mask();
  endtask

  task automatic t_disarm();
    wr_mask(7'h7F);
    set_ports(7'h00);
    cfg(1'b1);
    cfg(1'b0);
    set_ports(7'h11);
    check("R10 disarmed no detect", {6'b0, irq}, 7'h0);
    cfg(1'b1);
    set_ports(7'h13);
    check("R10 re-armed detect", {6'b0, irq}, 7'h1);
    cfg(1'b0);
    check("R10 disable keeps irq", {6'b0, irq}, 7'h1);
    rd_mask();
  endtask

  task automatic t_collide();
    wr_mask(7'h7F);
    set_ports(7'h00);
    cfg(1'b1);
    port_in = 7'h04;
    cyc(2);
    mask_rd = 1'b1;
    cyc(1);
    mask_rd = 1'b0;
    check("R11 access wins over hit", {6'b0, irq}, 7'h0);
    set_ports(7'h00);
    check("R11 detection ended", {6'b0, irq}, 7'h0);
  endtask

  task automatic t_resnap();
    wr_mask(7'h7F);
    set_ports(7'h00);
    cfg(1'b1);
    port_in = 7'h3C;
    cyc(2);
    cfg(1'b1);
    cyc(4);
    check("R12 new snapshot matches", {6'b0, irq}, 7'h0);
    set_ports(7'h3D);
    check("R12 change from new snapshot", {6'b0, irq}, 7'h1);
    rd_mask();
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_mask_rw();
    t_basic_hit();
    t_masked();
    t_pulse();
    t_disarm();
    t_collide();
    t_resnap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule